// File: doc/BRIEF.md
# Token-Ring Serial Bus Transmit Controller

This block is the send half of one board's attachment to a shared serial bus. The boards are wired in a ring, and a single one-bit token travels around it. A board may drive the bus only while it holds the token. When local logic has a buffered message, it raises `send_req`. The controller then asks for the token and waits for it to arrive on `tok_in`. Once it holds the token, it pulls the message from a byte-wide valid/ready stream and shifts it out on `tx_line`. The message is an address byte, then a length byte, then exactly that many data bytes. The controller then reports the end of the send and passes the token to the next board with a one-cycle pulse on `tok_out`.

If the token arrives while nothing is pending, it is passed on at once and the bus stays idle. Each byte goes out as a frame of eleven bit-times. Each bit-time lasts `CLK_PER_BIT` clocks. The line idles high.

The sequencer moves through these states:

- ST_IDLE: no token held and nothing pending.
- ST_WAIT: a request is pending and the token is being awaited.
- ST_HOLD: the reset-time token holder on its first cycle.
- ST_LOAD: the token is held and the next byte is awaited.
- ST_SHIFT: a frame is on the line.
- ST_DONE: the end of the send is reported.
- ST_PASS: the token is forwarded.

The transitions are:

- IDLE to WAIT when a request appears.
- IDLE to PASS when the token arrives with no request.
- IDLE to LOAD when the token and a request arrive together.
- WAIT to LOAD when the token arrives.
- WAIT to IDLE when the request is withdrawn.
- HOLD to LOAD or to PASS, depending on whether a request is pending.
- LOAD to SHIFT when a byte is accepted.
- SHIFT to LOAD after a frame that is not the last one.
- SHIFT to DONE after the last frame.
- DONE to PASS.
- PASS to IDLE.

Top module: `tring_tx_ctrl`

## Requirements
- R1: While reset is held and right after it, `tx_line` is 1, and `tok_out`, `tok_req`, `src_ready` and `send_done` are 0 (for a board that is not the initial holder).
- R2: A rising edge on `tok_in` while no send is pending produces exactly one one-cycle pulse on `tok_out`, in the cycle after the edge is sampled. No frame appears on `tx_line`.
- R3: A pending `send_req` raises `tok_req` one cycle later. While waiting, `src_ready` stays 0 and `tx_line` stays high. Withdrawing `send_req` before the token arrives drops `tok_req`.
- R4: Each byte is framed as eleven bit-times of `CLK_PER_BIT` clocks each, in this order:
  - bit-time 0: start bit 0;
  - bit-times 1 to 8: the eight data bits, LSB first;
  - bit-time 9: an even-parity bit, equal to the XOR of the data bits;
  - bit-time 10: stop bit 1.
- R5: The bytes leave in stream order: address byte, length byte N, then exactly N data bytes. No further stream byte is accepted for that message.
- R6: `send_done` pulses for one cycle after the last stop bit ends. `tok_out` pulses in the very next cycle. `tok_out` never pulses while a frame is on the line.
- R7: A length byte of 0 sends only the address and length frames.
- R8: `tok_in` is edge-detected. A token input held high for many cycles is forwarded once.
- R9: With `HOLDER` = 1 the board leaves reset owning the token. With no request pending, it forwards the token with a single pulse shortly after reset.
- R10: If the stream stalls between bytes, `tx_line` stays high and `src_ready` stays 1 until the next byte is offered. Transmission then resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| send_req | input | 1 | Level: a message is buffered and waiting to go |
| tok_req | output | 1 | Token wanted (waiting for the token) |
| src_data | input | BYTE_W | Message byte from the source stream |
| src_valid | input | 1 | `src_data` holds a byte |
| src_ready | output | 1 | Controller accepts the byte this cycle |
| tok_in | input | 1 | Token from the previous board (edge-detected) |
| tok_out | output | 1 | One-cycle token pulse to the next board |
| tx_line | output | 1 | Serial data line, idle high |
| send_done | output | 1 | One-cycle end-of-message pulse |

## Verification
The bound checker watches properties that hold on every cycle:

- `tok_out` and `send_done` are single-cycle pulses.
- The token leaves the cycle after the end of a send.
- The line stays high while the token is awaited or while a byte is awaited.
- The block never offers to take data and forward the token at the same time.

The bench's scenarios show the rest:

- Frame bit order and parity, sampled mid-bit.
- Byte order, and the count of data bytes taken for a given length byte.
- Refusal of a surplus byte.
- The zero-length case.
- Edge detection of a held token.
- Withdrawal of a request.
- Power-up as the holder.

// File: rtl/tring_pkg.sv
package tring_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_HOLD,
        ST_LOAD,
        ST_SHIFT,
        ST_DONE,
        ST_PASS
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_LEN,
        PH_DATA
    } msg_phase_t;

endpackage

// File: rtl/tring_tok_edge.sv
module tring_tok_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tok_in,
    output logic tok_rise
);
    logic tok_q;

    always_ff @(posedge clk) begin
        if (!rst_n) tok_q <= 1'b0;
        else        tok_q <= tok_in;
    end

    // A token is a 0->1 transition; a level held high counts once.
    assign tok_rise = tok_in & ~tok_q;
endmodule

// File: rtl/tring_frame_tx.sv
module tring_frame_tx #(
    parameter int BYTE_W      = 8,
    parameter int CLK_PER_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] din,
    output logic              done,
    output logic              line
);
    localparam int FRAME_BITS = BYTE_W + 3;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam int DIV_W      = $clog2(CLK_PER_BIT + 1);

    logic [FRAME_BITS-1:0] shreg;
    logic [CNT_W-1:0]      bit_idx;
    logic [DIV_W-1:0]      div;
    logic                  busy_q;
    logic                  tick;
    logic                  last_bit;

    assign tick     = (div == DIV_W'(CLK_PER_BIT - 1));
    assign last_bit = (bit_idx == CNT_W'(FRAME_BITS - 1));
    assign done     = busy_q & tick & last_bit;
    assign line     = busy_q ? shreg[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '1;
            bit_idx <= '0;
            div     <= '0;
            busy_q  <= 1'b0;
        end else if (start && !busy_q) begin
            // stop, even parity, data (LSB shifted first), start
            shreg   <= {1'b1, ^din, din, 1'b0};
            bit_idx <= '0;
            div     <= '0;
            busy_q  <= 1'b1;
        end else if (busy_q) begin
            if (tick) begin
                div <= '0;
                if (last_bit) begin
                    busy_q <= 1'b0;
                end else begin
                    shreg   <= {1'b1, shreg[FRAME_BITS-1:1]};
                    bit_idx <= bit_idx + CNT_W'(1);
                end
            end else begin
                div <= div + DIV_W'(1);
            end
        end
    end
endmodule

// File: rtl/tring_msg_track.sv
module tring_msg_track
    import tring_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              accept,
    input  logic [BYTE_W-1:0] din,
    input  logic              sent,
    output logic              last_byte
);
    msg_phase_t        phase;
    logic [BYTE_W-1:0] rem;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            phase <= PH_ADDR;
            rem   <= '0;
        end else begin
            if (accept && phase == PH_LEN)       rem <= din;
            else if (accept && phase == PH_DATA) rem <= rem - BYTE_W'(1);
            if (sent) begin
                unique case (phase)
                    PH_ADDR: phase <= PH_LEN;
                    PH_LEN:  phase <= PH_DATA;
                    default: phase <= PH_DATA;
                endcase
            end
        end
    end

    // After the length byte, the message ends once no data bytes remain.
    assign last_byte = (phase != PH_ADDR) && (rem == '0);
endmodule

// File: rtl/tring_tx_ctrl.sv
module tring_tx_ctrl
    import tring_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int CLK_PER_BIT = 4,
    parameter bit HOLDER      = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send_req,
    output logic              tok_req,
    input  logic [BYTE_W-1:0] src_data,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic              tok_in,
    output logic              tok_out,
    output logic              tx_line,
    output logic              send_done
);
    localparam seq_state_t RESET_ST = HOLDER ? ST_HOLD : ST_IDLE;

    seq_state_t state_q, state_d;
    logic tok_rise;
    logic fr_done;
    logic accept;
    logic last_byte;
    logic trk_clear;

    tring_tok_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .tok_in   (tok_in),
        .tok_rise (tok_rise)
    );

    tring_frame_tx #(
        .BYTE_W      (BYTE_W),
        .CLK_PER_BIT (CLK_PER_BIT)
    ) u_frame (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .din   (src_data),
        .done  (fr_done),
        .line  (tx_line)
    );

    tring_msg_track #(
        .BYTE_W (BYTE_W)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (trk_clear),
        .accept    (accept),
        .din       (src_data),
        .sent      (fr_done),
        .last_byte (last_byte)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RESET_ST;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tok_rise)      state_d = send_req ? ST_LOAD : ST_PASS;
                else if (send_req) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (tok_rise)       state_d = ST_LOAD;
                else if (!send_req) state_d = ST_IDLE;
            end
            ST_HOLD:  state_d = send_req ? ST_LOAD : ST_PASS;
            ST_LOAD:  if (src_valid) state_d = ST_SHIFT;
            ST_SHIFT: if (fr_done) state_d = last_byte ? ST_DONE : ST_LOAD;
            ST_DONE:  state_d = ST_PASS;
            ST_PASS:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        tok_req   = (state_q == ST_WAIT);
        src_ready = (state_q == ST_LOAD);
        send_done = (state_q == ST_DONE);
        tok_out   = (state_q == ST_PASS);
        accept    = src_ready & src_valid;
        trk_clear = (state_q == ST_PASS);
    end
endmodule

// File: rtl/tring_tx_chk.sv
module tring_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tok_req,
    input logic src_ready,
    input logic tok_out,
    input logic tx_line,
    input logic send_done
);
    p_tok_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tok_out |=> !tok_out);

    p_wait_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tok_req |-> (tx_line && !src_ready));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        send_done |=> !send_done);

    p_pass_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        send_done |=> tok_out);

    p_owner_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> !tok_out);

    p_gap_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> tx_line);
endmodule

bind tring_tx_ctrl tring_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok_req   (tok_req),
    .src_ready (src_ready),
    .tok_out   (tok_out),
    .tx_line   (tx_line),
    .send_done (send_done)
);

// File: tb/tb_tring_tx_ctrl.sv
module tb_tring_tx_ctrl;
    localparam int CPB = 4;
    localparam int BW  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          send_req = 1'b0, tok_in = 1'b0, src_valid = 1'b0;
    logic [BW-1:0] src_data = '0;
    logic          tok_req, src_ready, tok_out, tx_line, send_done;
    logic          h_req, h_rdy, h_tok, h_line, h_done;

    tring_tx_ctrl #(.BYTE_W(BW), .CLK_PER_BIT(CPB), .HOLDER(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .send_req(send_req), .tok_req(tok_req),
        .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
        .tok_in(tok_in), .tok_out(tok_out), .tx_line(tx_line), .send_done(send_done));

    tring_tx_ctrl #(.BYTE_W(BW), .CLK_PER_BIT(CPB), .HOLDER(1'b1)) dut_hold (
        .clk(clk), .rst_n(rst_n), .send_req(1'b0), .tok_req(h_req),
        .src_data('0), .src_valid(1'b0), .src_ready(h_rdy),
        .tok_in(1'b0), .tok_out(h_tok), .tx_line(h_line), .send_done(h_done));

    int n_chk = 0, n_fail = 0, frames = 0, tok_during = 0;
    bit finished = 1'b0;
    logic [BW-1:0] exp_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: samples mid-bit, compares against the scoreboard queue
    logic        mon_act = 1'b0;
    int          mon_cnt = 0;
    logic [10:0] mon_bits;

    task automatic frame_check();
        logic [BW-1:0] got, exp;
        frames++;
        got = mon_bits[8:1];
        if (exp_q.size() == 0) begin
            check(1'b0, "R5", "unexpected frame", int'(got), -1);
        end else begin
            exp = exp_q.pop_front();
            check(got == exp, "R5", "byte order/value", int'(got), int'(exp));
        end
        check(mon_bits[0] == 1'b0, "R4", "start bit", int'(mon_bits[0]), 0);
        check(mon_bits[9] == ^got, "R4", "even parity", int'(mon_bits[9]), int'(^got));
        check(mon_bits[10] == 1'b1, "R4", "stop bit", int'(mon_bits[10]), 1);
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mon_act && tx_line === 1'b0) begin
                mon_act = 1'b1;
                mon_cnt = 0;
            end
            if (mon_act) begin
                if (tok_out) tok_during++;
                if (mon_cnt % CPB == CPB / 2) mon_bits[mon_cnt / CPB] = tx_line;
                if (mon_cnt == 10 * CPB + CPB / 2) begin
                    mon_act = 1'b0;
                    frame_check();
                end else begin
                    mon_cnt++;
                end
            end
        end
    end

    task automatic pulse_token();
        tok_in = 1'b1;
        @(negedge clk);
        tok_in = 1'b0;
    endtask

    task automatic feed(input logic [BW-1:0] msg[$], input int gap, input bit extra);
        for (int i = 0; i < msg.size(); i++) begin
            if (gap > 0 && i > 1) begin
                src_valid = 1'b0;
                repeat (gap) @(negedge clk);
                check(src_ready == 1'b1 && tx_line == 1'b1, "R10", "stalled: ready and line high",
                      int'({src_ready, tx_line}), 3);
            end
            src_valid = 1'b1;
            src_data  = msg[i];
            while (!src_ready) @(negedge clk);
            @(negedge clk);
        end
        if (extra) begin
            src_valid = 1'b1;
            src_data  = 8'hEE;
        end else begin
            src_valid = 1'b0;
        end
    endtask

    task automatic send_msg(input logic [BW-1:0] addr, input int n, input int gap, input bit extra);
        logic [BW-1:0] msg[$];
        int f0;
        msg.push_back(addr);
        msg.push_back(BW'(n));
        for (int i = 0; i < n; i++) msg.push_back(BW'(i * 37 + n + 1));
        foreach (msg[k]) exp_q.push_back(msg[k]);
        f0 = frames;
        send_req = 1'b1;
        repeat (3) @(negedge clk);
        check(tok_req == 1'b1, "R3", "tok_req while waiting", int'(tok_req), 1);
        check(src_ready == 1'b0 && tx_line == 1'b1, "R3", "quiet before token",
              int'({src_ready, tx_line}), 1);
        pulse_token();
        fork
            feed(msg, gap, extra);
            begin
                while (!send_done) @(negedge clk);
            end
        join
        check(exp_q.size() == 0 && !mon_act, "R6", "all frames out at send_done",
              exp_q.size(), 0);
        check(frames - f0 == n + 2, (n == 0) ? "R7" : "R5", "frame count",
              frames - f0, n + 2);
        send_req = 1'b0;
        @(negedge clk);
        check(tok_out == 1'b1 && send_done == 1'b0, "R6", "token passed after done",
              int'(tok_out), 1);
        check(src_ready == 1'b0, "R5", "surplus byte refused", int'(src_ready), 0);
        @(negedge clk);
        check(tok_out == 1'b0, "R2", "tok_out one cycle", int'(tok_out), 0);
        src_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int cnt, hcnt, f0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(tx_line == 1'b1, "R1", "line idle in reset", int'(tx_line), 1);
        check({tok_out, tok_req, src_ready, send_done} == 4'b0, "R1", "outputs low in reset",
              int'({tok_out, tok_req, src_ready, send_done}), 0);
        rst_n = 1'b1;
        cnt = 0; hcnt = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            cnt  += int'(tok_out);
            hcnt += int'(h_tok);
        end
        check(cnt == 0 && tx_line == 1'b1, "R1", "non-holder silent after reset", cnt, 0);
        check(hcnt == 1, "R9", "holder forwards token once", hcnt, 1);

        // R2 pass-through
        f0 = frames;
        tok_in = 1'b1;
        @(negedge clk);
        tok_in = 1'b0;
        check(tok_out == 1'b1, "R2", "forward next clock", int'(tok_out), 1);
        @(negedge clk);
        check(tok_out == 1'b0, "R2", "pulse width one", int'(tok_out), 0);
        repeat (3) @(negedge clk);
        check(frames == f0 && tx_line == 1'b1, "R2", "no bus activity", frames - f0, 0);

        // R8 held token counts once
        cnt = 0;
        tok_in = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (i == 5) tok_in = 1'b0;
            cnt += int'(tok_out);
        end
        check(cnt == 1, "R8", "held token forwarded once", cnt, 1);

        // R3 withdrawn request
        send_req = 1'b1;
        repeat (2) @(negedge clk);
        check(tok_req == 1'b1, "R3", "request raised", int'(tok_req), 1);
        send_req = 1'b0;
        repeat (2) @(negedge clk);
        check(tok_req == 1'b0, "R3", "request withdrawn", int'(tok_req), 0);
        pulse_token();
        check(tok_out == 1'b1, "R3", "token passed after withdraw", int'(tok_out), 1);
        repeat (3) @(negedge clk);

        send_msg(8'h05, 3, 0, 1'b0);    // R4 R5 R6
        send_msg(8'h81, 0, 0, 1'b0);    // R7
        send_msg(8'h3C, 6, 60, 1'b1);   // R10 and surplus byte (R5)
        send_msg(8'hA7, 20, 0, 1'b0);   // R5 longer body

        check(tok_during == 0, "R6", "no token pulse during a frame", tok_during, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule